// File: doc/BRIEF.md
# Sixteen-Opcode Instruction Field Decoder

This block is a purely combinational decoder for a 16-bit instruction word. The instruction set has eight general registers and a load/store structure. From one word it produces the opcode, the three register index fields and the branch condition mask. It also produces a 16-bit immediate, which is sign- or zero-extended from whichever field the instruction format defines, and a set of control flags for the execute and memory stages.

The decoder holds no state and makes no memory access. A pipeline places it between the instruction register and the operand fetch logic. The control flags tell the later stages whether the second operand comes from the immediate, whether the condition codes are rewritten, and which kind of memory access is needed. They also mark whether the link register is written, whether the word is a trap, and whether it is a reserved or ignored opcode. Reserved and ignored opcodes are no-ops, not faults.

Top module: `instr_field_decoder`

## Requirements
- R1: `opcode` equals instruction bits 15:12. `cond_mask` equals bits 11:9, with bit 11 = negative, bit 10 = zero and bit 9 = positive.
- R2: `dst_idx` equals bits 11:9, `src1_idx` equals bits 8:6 and `src2_idx` equals bits 2:0, for every opcode.
- R3: For opcodes 0, 2, 3, 10, 11 and 14, `imm_value` is bits 8:0 sign-extended from bit 8. `use_imm` is 0.
- R4: For opcodes 1 and 5, bit 5 = 1 gives `use_imm` = 1 and `imm_value` = bits 4:0 sign-extended from bit 4. Bit 5 = 0 gives `use_imm` = 0 and `imm_value` = 0.
- R5: For opcodes 6 and 7, `imm_value` is bits 5:0 sign-extended from bit 5. `use_imm` is 0.
- R6: For opcode 4, bit 11 = 1 gives `use_imm` = 1 and `imm_value` = bits 10:0 sign-extended from bit 10. Bit 11 = 0 (base-register target) gives `use_imm` = 0 and `imm_value` = 0.
- R7: For opcode 15, `imm_value` is bits 7:0 zero-extended, `is_trap` = 1 and `use_imm` = 0.
- R8: For opcodes 8, 9, 12 and 13, `imm_value` = 0 and `use_imm` = 0.
- R9: `cc_write` = 1 exactly for opcodes 1, 2, 5, 6, 9, 10 and 14.
- R10: `mem_read` = 1 exactly for opcodes 2, 6 and 10. `mem_write` = 1 exactly for opcodes 3, 7 and 11. `mem_indirect` = 1 exactly for opcodes 10 and 11.
- R11: `link_write` = 1 exactly for opcodes 4 and 15.
- R12: `is_reserved` = 1 only for opcode 13 and `is_ignored` = 1 only for opcode 8. For those two opcodes, `cc_write`, all memory flags, `link_write` and `is_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| opcode | output | 4 | Opcode field |
| cond_mask | output | 3 | Branch condition mask (n,z,p) |
| dst_idx | output | 3 | Destination or store-source register |
| src1_idx | output | 3 | First source or base register |
| src2_idx | output | 3 | Second source register |
| imm_value | output | 16 | Extended immediate or offset |
| use_imm | output | 1 | Immediate replaces a register operand or target |
| cc_write | output | 1 | Condition codes are updated |
| mem_read | output | 1 | Data memory load |
| mem_write | output | 1 | Data memory store |
| mem_indirect | output | 1 | Address goes through a pointer in memory |
| link_write | output | 1 | Return address written to the link register |
| is_trap | output | 1 | Trap instruction |
| is_reserved | output | 1 | Reserved opcode, treated as no-op |
| is_ignored | output | 1 | Ignored opcode, treated as no-op |

## Verification
The hardest cases to reach are the ones where the sign bit of a field is set while the bits just above that field hold the opposite value. Only those words show whether the extension uses the right bit position for the opcode. A word whose upper payload bits copy the sign looks correct even when the width is wrong. Directed words therefore pair each format's sign bit with the bit one position higher, in both polarities. The formats covered are the 5-, 6-, 9- and 11-bit fields and the zero-extended 8-bit trap vector. The mode bit of the add/and and subroutine-jump forms is forced both ways. Seeded random words then cover all opcodes.

// File: rtl/ifd_pkg.sv
package ifd_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_BRANCH = 4'd0,
      OPC_ADD    = 4'd1,
      OPC_LOAD   = 4'd2,
      OPC_STORE  = 4'd3,
      OPC_CALL   = 4'd4,
      OPC_AND    = 4'd5,
      OPC_LOADB  = 4'd6,
      OPC_STOREB = 4'd7,
      OPC_IRET   = 4'd8,
      OPC_NOT    = 4'd9,
      OPC_LOADI  = 4'd10,
      OPC_STOREI = 4'd11,
      OPC_JUMP   = 4'd12,
      OPC_RSVD   = 4'd13,
      OPC_ADDR   = 4'd14,
      OPC_TRAP   = 4'd15
   } opc_e;

   typedef enum logic [2:0] {
      IMM_NONE,
      IMM_S5,
      IMM_S6,
      IMM_S9,
      IMM_S11,
      IMM_Z8
   } imm_sel_e;

   typedef struct packed {
      logic     use_imm;
      logic     cc_write;
      logic     mem_read;
      logic     mem_write;
      logic     mem_indirect;
      logic     link_write;
      logic     is_trap;
      logic     is_reserved;
      logic     is_ignored;
      imm_sel_e imm_sel;
   } ctrl_t;

endpackage

// File: rtl/ifd_ext.sv
module ifd_ext #(
   parameter int IN_W    = 9,
   parameter int OUT_W   = 16,
   parameter bit SIGNED  = 1'b1
) (
   input  logic [IN_W-1:0]  field,
   output logic [OUT_W-1:0] ext
);
   localparam int PAD_W = OUT_W - IN_W;

   if (IN_W < 1 || IN_W >= OUT_W) begin : g_bad_width
      $error("ifd_ext: IN_W must lie between 1 and OUT_W-1");
   end

   if (SIGNED) begin : g_signed
      assign ext = {{PAD_W{field[IN_W-1]}}, field};
   end else begin : g_zero
      assign ext = {{PAD_W{1'b0}}, field};
   end
endmodule

// File: rtl/ifd_ctrl.sv
module ifd_ctrl
   import ifd_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   input  logic             imm_mode_bit,
   input  logic             call_rel_bit,
   output ctrl_t            ctrl
);
   always_comb begin
      ctrl = '0;
      ctrl.imm_sel = IMM_NONE;
      unique case (opc_e'(opc))
         OPC_BRANCH: ctrl.imm_sel = IMM_S9;
         OPC_ADD, OPC_AND: begin
            ctrl.cc_write = 1'b1;
            ctrl.use_imm  = imm_mode_bit;
            ctrl.imm_sel  = imm_mode_bit ? IMM_S5 : IMM_NONE;
         end
         OPC_LOAD: begin
            ctrl.cc_write = 1'b1;
            ctrl.mem_read = 1'b1;
            ctrl.imm_sel  = IMM_S9;
         end
         OPC_STORE: begin
            ctrl.mem_write = 1'b1;
            ctrl.imm_sel   = IMM_S9;
         end
         OPC_CALL: begin
            ctrl.link_write = 1'b1;
            ctrl.use_imm    = call_rel_bit;
            ctrl.imm_sel    = call_rel_bit ? IMM_S11 : IMM_NONE;
         end
         OPC_LOADB: begin
            ctrl.cc_write = 1'b1;
            ctrl.mem_read = 1'b1;
            ctrl.imm_sel  = IMM_S6;
         end
         OPC_STOREB: begin
            ctrl.mem_write = 1'b1;
            ctrl.imm_sel   = IMM_S6;
         end
         OPC_IRET:  ctrl.is_ignored = 1'b1;
         OPC_NOT:   ctrl.cc_write   = 1'b1;
         OPC_LOADI: begin
            ctrl.cc_write     = 1'b1;
            ctrl.mem_read     = 1'b1;
            ctrl.mem_indirect = 1'b1;
            ctrl.imm_sel      = IMM_S9;
         end
         OPC_STOREI: begin
            ctrl.mem_write    = 1'b1;
            ctrl.mem_indirect = 1'b1;
            ctrl.imm_sel      = IMM_S9;
         end
         OPC_JUMP:  ctrl.imm_sel     = IMM_NONE;
         OPC_RSVD:  ctrl.is_reserved = 1'b1;
         OPC_ADDR: begin
            ctrl.cc_write = 1'b1;
            ctrl.imm_sel  = IMM_S9;
         end
         OPC_TRAP: begin
            ctrl.link_write = 1'b1;
            ctrl.is_trap    = 1'b1;
            ctrl.imm_sel    = IMM_Z8;
         end
         default: ctrl = '0;
      endcase
   end
endmodule

// File: rtl/ifd_imm.sv
module ifd_imm
   import ifd_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int S5_W    = 5,
   parameter int S6_W    = 6,
   parameter int S9_W    = 9,
   parameter int S11_W   = 11,
   parameter int Z8_W    = 8
) (
   input  logic [S11_W-1:0]  payload,
   input  imm_sel_e          sel,
   output logic [WORD_W-1:0] imm
);
   logic [WORD_W-1:0] ext_s5, ext_s6, ext_s9, ext_s11, ext_z8;

   ifd_ext #(.IN_W(S5_W),  .OUT_W(WORD_W), .SIGNED(1'b1)) u_s5
      (.field(payload[S5_W-1:0]),  .ext(ext_s5));
   ifd_ext #(.IN_W(S6_W),  .OUT_W(WORD_W), .SIGNED(1'b1)) u_s6
      (.field(payload[S6_W-1:0]),  .ext(ext_s6));
   ifd_ext #(.IN_W(S9_W),  .OUT_W(WORD_W), .SIGNED(1'b1)) u_s9
      (.field(payload[S9_W-1:0]),  .ext(ext_s9));
   ifd_ext #(.IN_W(S11_W), .OUT_W(WORD_W), .SIGNED(1'b1)) u_s11
      (.field(payload[S11_W-1:0]), .ext(ext_s11));
   ifd_ext #(.IN_W(Z8_W),  .OUT_W(WORD_W), .SIGNED(1'b0)) u_z8
      (.field(payload[Z8_W-1:0]),  .ext(ext_z8));

   always_comb begin
      unique case (sel)
         IMM_S5:  imm = ext_s5;
         IMM_S6:  imm = ext_s6;
         IMM_S9:  imm = ext_s9;
         IMM_S11: imm = ext_s11;
         IMM_Z8:  imm = ext_z8;
         default: imm = '0;
      endcase
   end
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
   import ifd_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int REG_W  = 3
) (
   input  logic [WORD_W-1:0] instr,
   output logic [OPC_W-1:0]  opcode,
   output logic [REG_W-1:0]  cond_mask,
   output logic [REG_W-1:0]  dst_idx,
   output logic [REG_W-1:0]  src1_idx,
   output logic [REG_W-1:0]  src2_idx,
   output logic [WORD_W-1:0] imm_value,
   output logic              use_imm,
   output logic              cc_write,
   output logic              mem_read,
   output logic              mem_write,
   output logic              mem_indirect,
   output logic              link_write,
   output logic              is_trap,
   output logic              is_reserved,
   output logic              is_ignored
);
   localparam int OPC_LSB   = WORD_W - OPC_W;
   localparam int DST_LSB   = OPC_LSB - REG_W;
   localparam int SRC1_LSB  = DST_LSB - REG_W;
   localparam int MODE_BIT  = 5;
   localparam int CALL_BIT  = DST_LSB + REG_W - 1;
   localparam int PAYLOAD_W = CALL_BIT;

   if (WORD_W != 16 || REG_W != 3) begin : g_bad_geometry
      $error("instr_field_decoder: field layout needs a 16-bit word and 3-bit register fields");
   end

   ctrl_t ctrl;

   assign opcode    = instr[WORD_W-1:OPC_LSB];
   assign cond_mask = instr[OPC_LSB-1:DST_LSB];
   assign dst_idx   = instr[OPC_LSB-1:DST_LSB];
   assign src1_idx  = instr[DST_LSB-1:SRC1_LSB];
   assign src2_idx  = instr[REG_W-1:0];

   ifd_ctrl u_ctrl (
      .opc          (opcode),
      .imm_mode_bit (instr[MODE_BIT]),
      .call_rel_bit (instr[CALL_BIT]),
      .ctrl         (ctrl)
   );

   ifd_imm #(.WORD_W(WORD_W), .S11_W(PAYLOAD_W)) u_imm (
      .payload (instr[PAYLOAD_W-1:0]),
      .sel     (ctrl.imm_sel),
      .imm     (imm_value)
   );

   assign use_imm      = ctrl.use_imm;
   assign cc_write     = ctrl.cc_write;
   assign mem_read     = ctrl.mem_read;
   assign mem_write    = ctrl.mem_write;
   assign mem_indirect = ctrl.mem_indirect;
   assign link_write   = ctrl.link_write;
   assign is_trap      = ctrl.is_trap;
   assign is_reserved  = ctrl.is_reserved;
   assign is_ignored   = ctrl.is_ignored;
endmodule

// File: rtl/ifd_checker.sv
module ifd_checker (
   input logic [15:0] instr,
   input logic [3:0]  opcode,
   input logic [2:0]  cond_mask,
   input logic [2:0]  dst_idx,
   input logic [2:0]  src1_idx,
   input logic [2:0]  src2_idx,
   input logic [15:0] imm_value,
   input logic        use_imm,
   input logic        cc_write,
   input logic        mem_read,
   input logic        mem_write,
   input logic        mem_indirect,
   input logic        link_write,
   input logic        is_trap,
   input logic        is_reserved,
   input logic        is_ignored
);
   always_comb begin
      if (instr == 16'h0000) begin
         assert_base_word_R1: assert (opcode == 4'd0 && cond_mask == 3'd0 && dst_idx == 3'd0);
      end
      if (opcode == 4'd6 || opcode == 4'd7) begin
         assert_six_bit_sign_R5: assert (imm_value[15:5] == {11{instr[5]}});
      end
      if (mem_indirect) begin
         assert_indirect_has_access_R10: assert (mem_read != mem_write);
      end
      assert_no_cc_on_store_R9: assert (!(cc_write && mem_write));
      assert_noop_quiet_R12: assert (!((is_reserved || is_ignored) &&
         (cc_write || mem_read || mem_write || link_write || is_trap || use_imm)));
      if (is_trap) begin
         assert_trap_zero_ext_R7: assert (imm_value[15:8] == 8'h00 && link_write);
      end
      if (!use_imm && (opcode == 4'd1 || opcode == 4'd5 || opcode == 4'd4)) begin
         assert_reg_form_no_imm_R4: assert (imm_value == 16'h0000);
      end
      assert_src_fields_R2: assert (src1_idx == instr[8:6] && src2_idx == instr[2:0]);
   end
endmodule

bind instr_field_decoder ifd_checker u_ifd_checker (.*);

// File: tb/test_instr_field_decoder.sv
module test_instr_field_decoder;
   logic        clk = 1'b0;
   logic [15:0] instr;
   logic [3:0]  opcode;
   logic [2:0]  cond_mask, dst_idx, src1_idx, src2_idx;
   logic [15:0] imm_value;
   logic        use_imm, cc_write, mem_read, mem_write, mem_indirect;
   logic        link_write, is_trap, is_reserved, is_ignored;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   instr_field_decoder i_instr_field_decoder (
      .instr(instr), .opcode(opcode), .cond_mask(cond_mask), .dst_idx(dst_idx),
      .src1_idx(src1_idx), .src2_idx(src2_idx), .imm_value(imm_value),
      .use_imm(use_imm), .cc_write(cc_write), .mem_read(mem_read),
      .mem_write(mem_write), .mem_indirect(mem_indirect), .link_write(link_write),
      .is_trap(is_trap), .is_reserved(is_reserved), .is_ignored(is_ignored)
   );

   function automatic logic [15:0] sx(input logic [15:0] w, input int hi);
      logic [15:0] r;
      for (int b = 0; b < 16; b++) r[b] = (b <= hi) ? w[b] : w[hi];
      return r;
   endfunction

   function automatic logic [15:0] exp_imm(input logic [15:0] w);
      int op = int'(w[15:12]);
      case (op)
         0, 2, 3, 10, 11, 14: return sx(w, 8);
         1, 5:  return w[5] ? sx(w, 4) : 16'h0000;
         6, 7:  return sx(w, 5);
         4:     return w[11] ? sx(w, 10) : 16'h0000;
         15:    return {8'h00, w[7:0]};
         default: return 16'h0000;
      endcase
   endfunction

   // flag order: use_imm cc rd wr ind link trap rsvd ign
   function automatic logic [8:0] exp_flags(input logic [15:0] w);
      int op = int'(w[15:12]);
      logic [8:0] f;
      f[8] = ((op == 1 || op == 5) && w[5]) || (op == 4 && w[11]);
      f[7] = (op == 1 || op == 2 || op == 5 || op == 6 || op == 9 || op == 10 || op == 14);
      f[6] = (op == 2 || op == 6 || op == 10);
      f[5] = (op == 3 || op == 7 || op == 11);
      f[4] = (op == 10 || op == 11);
      f[3] = (op == 4 || op == 15);
      f[2] = (op == 15);
      f[1] = (op == 13);
      f[0] = (op == 8);
      return f;
   endfunction

   function automatic string imm_tag(input logic [15:0] w);
      case (int'(w[15:12]))
         0, 2, 3, 10, 11, 14: return "R3";
         1, 5: return "R4";
         6, 7: return "R5";
         4:    return "R6";
         15:   return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp,
                        input logic [15:0] w);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] w);
      logic [8:0] ef;
      logic [8:0] af;
      @(posedge clk);
      instr = w;
      @(negedge clk);
      ef = exp_flags(w);
      af = {use_imm, cc_write, mem_read, mem_write, mem_indirect,
            link_write, is_trap, is_reserved, is_ignored};
      check("R1", {9'd0, opcode, cond_mask}, {9'd0, w[15:12], w[11:9]}, w);
      check("R2", {7'd0, dst_idx, src1_idx, src2_idx}, {7'd0, w[11:9], w[8:6], w[2:0]}, w);
      check(imm_tag(w), imm_value, exp_imm(w), w);
      check("R9",  {15'd0, af[7]}, {15'd0, ef[7]}, w);
      check("R10", {13'd0, af[6:4]}, {13'd0, ef[6:4]}, w);
      check("R11", {15'd0, af[3]}, {15'd0, ef[3]}, w);
      check("R12", {7'd0, af}, {7'd0, ef}, w);
   endtask

   initial begin
      instr = 16'h0000;
      // zero word at start: branch with empty mask, zero offset
      apply(16'h0000);
      // every opcode with positive and negative payloads around each sign bit
      for (int op = 0; op < 16; op++) begin
         apply({op[3:0], 12'h000});
         apply({op[3:0], 12'hFFF});
         apply({op[3:0], 12'h010});  // R4: bit4 set, bit5 clear
         apply({op[3:0], 12'h030});  // R4: imm mode, negative 5-bit
         apply({op[3:0], 12'h020});  // R5: bit5 set
         apply({op[3:0], 12'h040});  // R5: bit6 set, bit5 clear
         apply({op[3:0], 12'h100});  // R3: sign bit 8
         apply({op[3:0], 12'h200});  // R3: bit9 set, sign clear
         apply({op[3:0], 12'h400});  // R6: bit10 with register form
         apply({op[3:0], 12'hC00});  // R6: relative form, negative
         apply({op[3:0], 12'h880});  // R7: bit7 set
         apply({op[3:0], 12'h5A5});
      end
      // seeded random words
      void'($urandom(32'h1F2E3D4C));
      for (int i = 0; i < 3000; i++) apply(16'($urandom()));
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule